// File: doc/BRIEF.md
# GPIO Port Register Core

This block is the register side of an eight-pin general-purpose I/O port. A serial bus slave, or any other host-side agent, drives a plain address, write-data, write-enable and read-data bus into it. Behind that bus sit the settings that decide how each pin behaves: its direction, the value it drives, whether its read value is inverted, whether a pull resistor is switched in and which way it pulls, and how hard the output stage drives. One port-wide bit also chooses push-pull or open-drain output stages.

From those settings the block derives, every cycle and without extra latency, the control vectors for an external pad model: output enable, output value, open-drain flag, pull enable, pull direction and a two-bit drive code per pin. The sampled pad levels come back in and are presented on the read bus, after per-bit inversion, at the input address. Change detection and interrupt signalling belong to a companion block.

Register addresses: 0x0 input view (read only), 0x1 output latch, 0x2 read inversion, 0x3 direction, 0x4 drive codes for pins 0 to 3, 0x5 drive codes for pins 4 to 7, 0x6 pull enable, 0x7 pull direction, 0x8 output mode. Writes take effect at the clock edge on which `wr_en` is high. Reads are combinational.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset the direction, output latch, pull direction and both drive-code registers read 0xFF; inversion, pull enable and output mode read 0x00; so every pin is an input, no pad is enabled and no pull is active.
- R2: A write to addresses 0x1 to 0x7 is read back unchanged from the next cycle on; at address 0x8 only bit 0 is stored and the other bits read 0.
- R3: Address 0x0 reads `pad_in` XOR the inversion register in the same cycle (inversion bit 1 flips that pin).
- R4: A write to address 0x0 changes no register.
- R5: Addresses 0x9 to 0xF read 0x00, and writes to them change no register.
- R6: A pin whose direction bit is 1 (input) never has its output enable asserted.
- R7: With output mode bit 0 = 0 (push-pull), a pin whose direction bit is 0 has `pad_oe` high, and `pad_out` equals the output latch on every pin.
- R8: With output mode bit 0 = 1 (open-drain), `pad_out` is 0 on every pin, `pad_od` is all ones, and an output pin asserts `pad_oe` only when its latch bit is 0.
- R9: `pad_pull_en` follows register 0x6 and `pad_pull_up` follows register 0x7 bit for bit (1 = pull up, 0 = pull down).
- R10: The drive code of pin i sits at `pad_drive[2i+1:2i]`; pins 0 to 3 take bits [2k+1:2k] of register 0x4, pins 4 to 7 take the same positions of register 0x5.
- R11: The output latch keeps a value written while a pin is an input and drives it as soon as the pin becomes an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rdata | output | 8 | Read data for `addr` |
| pad_in | input | 8 | Sampled pad levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin driven value |
| pad_od | output | 8 | Per-pin open-drain flag |
| pad_pull_en | output | 8 | Per-pin pull resistor enable |
| pad_pull_up | output | 8 | Per-pin pull direction, 1 = up |
| pad_drive | output | 16 | Two-bit drive code per pin |

## Verification
The bench targets the open-drain case where a latch bit of 1 must release the pin rather than drive it high; a design that kept the push-pull equations would show the enable asserted on those pins. It writes to the read-only input address and to the unmapped range, then reads every register back, catching a decoder that aliases those addresses onto a real register. It programs distinct drive codes per pin so that a swapped half or a reversed bit pair shows up in the drive vector, and it loads the output latch while pins are inputs to catch a design that gates the latch write by direction.

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int          N       = 8,
  parameter int          AW      = 4,
  parameter logic [N-1:0] DIR_RST = '1,
  parameter logic [N-1:0] OUT_RST = '1,
  parameter logic [N-1:0] PUP_RST = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic [N-1:0]    wdata,
  input  logic            wr_en,
  output logic [N-1:0]    rdata,
  input  logic [N-1:0]    pad_in,
  output logic [N-1:0]    pad_oe,
  output logic [N-1:0]    pad_out,
  output logic [N-1:0]    pad_od,
  output logic [N-1:0]    pad_pull_en,
  output logic [N-1:0]    pad_pull_up,
  output logic [2*N-1:0]  pad_drive
);

  localparam logic [AW-1:0] A_IN   = AW'(0);
  localparam logic [AW-1:0] A_OUT  = AW'(1);
  localparam logic [AW-1:0] A_INV  = AW'(2);
  localparam logic [AW-1:0] A_DIR  = AW'(3);
  localparam logic [AW-1:0] A_DRVL = AW'(4);
  localparam logic [AW-1:0] A_DRVH = AW'(5);
  localparam logic [AW-1:0] A_PEN  = AW'(6);
  localparam logic [AW-1:0] A_PUP  = AW'(7);
  localparam logic [AW-1:0] A_MODE = AW'(8);

  logic [N-1:0]   out_q, inv_q, dir_q, pen_q, pup_q;
  logic [2*N-1:0] drv_q;
  logic           od_q;
  logic [N-1:0]   in_view;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= OUT_RST;
      inv_q <= '0;
      dir_q <= DIR_RST;
      pen_q <= '0;
      pup_q <= PUP_RST;
      drv_q <= '1;
      od_q  <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        A_OUT:   out_q <= wdata;
        A_INV:   inv_q <= wdata;
        A_DIR:   dir_q <= wdata;
        A_DRVL:  drv_q[N-1:0] <= wdata;
        A_DRVH:  drv_q[2*N-1:N] <= wdata;
        A_PEN:   pen_q <= wdata;
        A_PUP:   pup_q <= wdata;
        A_MODE:  od_q  <= wdata[0];
        default: ;
      endcase
    end
  end

  assign in_view = pad_in ^ inv_q;

  always_comb begin
    case (addr)
      A_IN:    rdata = in_view;
      A_OUT:   rdata = out_q;
      A_INV:   rdata = inv_q;
      A_DIR:   rdata = dir_q;
      A_DRVL:  rdata = drv_q[N-1:0];
      A_DRVH:  rdata = drv_q[2*N-1:N];
      A_PEN:   rdata = pen_q;
      A_PUP:   rdata = pup_q;
      A_MODE:  rdata = {{(N-1){1'b0}}, od_q};
      default: rdata = '0;
    endcase
  end

  for (genvar i = 0; i < N; i++) begin : g_pin
    assign pad_oe[i]      = ~dir_q[i] & ~(od_q & out_q[i]);
    assign pad_out[i]     = out_q[i] & ~od_q;
    assign pad_od[i]      = od_q;
    assign pad_drive[2*i +: 2] = drv_q[2*i +: 2];
  end

  assign pad_pull_en = pen_q;
  assign pad_pull_up = pup_q;

endmodule

module gpio_port_regs_chk #(
  parameter int N  = 8,
  parameter int AW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [AW-1:0]  addr,
  input logic [N-1:0]   wdata,
  input logic           wr_en,
  input logic [N-1:0]   rdata,
  input logic [N-1:0]   pad_oe,
  input logic [N-1:0]   pad_out,
  input logic [N-1:0]   out_q,
  input logic [N-1:0]   inv_q,
  input logic [N-1:0]   dir_q,
  input logic [N-1:0]   pen_q,
  input logic [N-1:0]   pup_q,
  input logic [2*N-1:0] drv_q,
  input logic           od_q
);

  // R2
  wr_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(1)) |=> (out_q == $past(wdata)));

  // R2
  wr_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(3)) |=> (dir_q == $past(wdata)));

  // R4
  ro_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(0)) |=> ($stable(out_q) && $stable(inv_q) && $stable(dir_q)
      && $stable(pen_q) && $stable(pup_q) && $stable(drv_q) && $stable(od_q)));

  // R5
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr > AW'(8)) |=> ($stable(out_q) && $stable(inv_q) && $stable(dir_q)
      && $stable(pen_q) && $stable(pup_q) && $stable(drv_q) && $stable(od_q)));

  // R5
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr > AW'(8)) |-> (rdata == '0));

  // R6
  input_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & dir_q) == '0);

  // R8
  od_sink_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    od_q |-> (pad_out == '0 && (pad_oe & out_q) == '0));

endmodule

bind gpio_port_regs gpio_port_regs_chk #(.N(N), .AW(AW)) u_chk (.*);

// File: tb/gpio_port_regs_tb.sv
`timescale 1ns/1ps
module gpio_port_regs_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  rdata;
  logic [7:0]  pad_in = '0;
  logic [7:0]  pad_oe, pad_out, pad_od, pad_pull_en, pad_pull_up;
  logic [15:0] pad_drive;

  gpio_port_regs u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rdata(rdata), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_od(pad_od), .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up),
    .pad_drive(pad_drive)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    int          kind;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  event  samp;
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 1'b0;

  logic [7:0]  m_out = 8'hFF, m_inv = 8'h00, m_dir = 8'hFF, m_pen = 8'h00, m_pup = 8'hFF;
  logic [15:0] m_drv = 16'hFFFF;
  logic        m_od = 1'b0;

  function automatic logic [15:0] pick(int kind);
    case (kind)
      0: return {8'h00, rdata};
      1: return {8'h00, pad_oe};
      2: return {8'h00, pad_out};
      3: return {8'h00, pad_od};
      4: return {8'h00, pad_pull_en};
      5: return {8'h00, pad_pull_up};
      default: return pad_drive;
    endcase
  endfunction

  initial begin
    forever begin
      @(samp);
      while (sb.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = sb.pop_front();
        act = pick(it.kind);
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic push(int kind, logic [15:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic flush();
    #0.5;
    ->samp;
    #0.5;
  endtask

  function automatic logic [7:0] m_read(logic [3:0] a);
    case (a)
      4'h0: return pad_in ^ m_inv;
      4'h1: return m_out;
      4'h2: return m_inv;
      4'h3: return m_dir;
      4'h4: return m_drv[7:0];
      4'h5: return m_drv[15:8];
      4'h6: return m_pen;
      4'h7: return m_pup;
      4'h8: return {7'd0, m_od};
      default: return 8'h00;
    endcase
  endfunction

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      4'h1: m_out = d;
      4'h2: m_inv = d;
      4'h3: m_dir = d;
      4'h4: m_drv[7:0] = d;
      4'h5: m_drv[15:8] = d;
      4'h6: m_pen = d;
      4'h7: m_pup = d;
      4'h8: m_od = d[0];
      default: ;
    endcase
  endtask

  task automatic rd(logic [3:0] a, string tag);
    addr = a;
    push(0, {8'h00, m_read(a)}, tag);
    flush();
  endtask

  task automatic read_all(string tag);
    for (int a = 0; a < 16; a++) rd(4'(a), tag);
  endtask

  task automatic pads(string tag);
    logic [7:0] oe, po;
    for (int i = 0; i < 8; i++) begin
      oe[i] = !m_dir[i] && !(m_od && m_out[i]);
      po[i] = m_od ? 1'b0 : m_out[i];
    end
    push(1, {8'h00, oe}, tag);
    push(2, {8'h00, po}, tag);
    push(3, {8'h00, {8{m_od}}}, tag);
    push(4, {8'h00, m_pen}, tag);
    push(5, {8'h00, m_pup}, tag);
    push(6, m_drv, tag);
    flush();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset defaults on the bus and at the pads
    read_all("R1");
    pads("R1");

    // R3 inversion of the input view
    pad_in = 8'hA5;
    rd(4'h0, "R3");
    wr(4'h2, 8'h0F);
    rd(4'h0, "R3");
    pad_in = 8'h3C;
    rd(4'h0, "R3");

    // R2 readback of writable registers
    wr(4'h1, 8'h96); rd(4'h1, "R2");
    wr(4'h3, 8'h69); rd(4'h3, "R2");
    wr(4'h6, 8'hC3); rd(4'h6, "R2");
    wr(4'h7, 8'h3C); rd(4'h7, "R2");
    wr(4'h8, 8'hFE); rd(4'h8, "R2");
    wr(4'h8, 8'hFF); rd(4'h8, "R2");
    wr(4'h8, 8'h00); rd(4'h8, "R2");

    // R4 write to input address leaves all state alone
    wr(4'h0, 8'h55);
    read_all("R4");
    pads("R4");

    // R5 unmapped range
    wr(4'hC, 8'hFF);
    wr(4'hF, 8'hA5);
    wr(4'h9, 8'h01);
    read_all("R5");
    pads("R5");

    // R6 R7 push-pull
    wr(4'h3, 8'hF0);
    wr(4'h1, 8'h5A);
    pads("R7");
    push(1, 16'h000F, "R6");
    flush();

    // R8 open-drain
    wr(4'h8, 8'h01);
    pads("R8");
    push(1, 16'h0005, "R8");
    push(2, 16'h0000, "R8");
    flush();
    wr(4'h8, 8'h00);

    // R9 pull controls
    wr(4'h6, 8'h81);
    wr(4'h7, 8'h0F);
    push(4, 16'h0081, "R9");
    push(5, 16'h000F, "R9");
    flush();

    // R10 drive code layout
    wr(4'h4, 8'hE4);
    wr(4'h5, 8'h1B);
    push(6, 16'h1BE4, "R10");
    flush();
    pads("R10");

    // R11 latch while input, drive after turning to output
    wr(4'h3, 8'hFF);
    wr(4'h1, 8'h3C);
    push(1, 16'h0000, "R11");
    flush();
    wr(4'h3, 8'h00);
    push(1, 16'h00FF, "R11");
    push(2, 16'h003C, "R11");
    flush();
    pads("R11");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule